// File: doc/BRIEF.md
# Output Drive Calibration Sequencer

This block keeps the two 6-bit drive-strength codes of an output driver bank: one for the pull-up half (used when a pin drives a one) and one for the pull-down half (used when a pin drives a zero). An external sensing circuit compares each half against its target. It reports the result as a two-bit digital compare input that asks for a raise, a lower or no change. The sequencer never lets a code follow those requests freely. Once per fixed evaluation interval it moves each code by at most one step, and only when the driver that code controls is idle at that moment.

Eligibility comes from the state of the output bus. The pull-down code may move while every pin drives a one. The pull-up code may move while every pin drives a zero. Both may move while the bus is released to high impedance. A code that is not eligible when the interval ends skips that evaluation and waits for the next one.

A ready flag reports that calibration after power-up can be trusted. That needs a warm-up count of clock cycles plus at least one all-zeros read and one all-ones read on the bus, in either order. The reset input is asynchronous on assertion. The block releases it to its own logic in step with the clock, two cycles after the reset input goes high.

Top module: `drive_cal_seq`

## Requirements
- R1: While reset is asserted, and right after it, both codes equal 32 (mid-scale) and `cal_ready` is 0.
- R2: Codes change only on an evaluation edge. The first evaluation edge is the 64th rising clock edge after the block leaves reset (reset leaves two edges after `rst_n` rises). After that, evaluation edges come every 64 edges.
- R3: Compare inputs use 2'b01 for raise (+1), 2'b10 for lower (-1), and 2'b00 or 2'b11 for hold. A code moves by at most one step per evaluation.
- R4: Codes saturate. A raise at 63 leaves 63, and a lower at 0 leaves 0.
- R5: The pull-down code `pd_code` is eligible only when `out_en` is 0, or when `out_en` is 1 and every bit of `out_data` is 1.
- R6: The pull-up code `pu_code` is eligible only when `out_en` is 0, or when `out_en` is 1 and every bit of `out_data` is 0.
- R7: A code that is not eligible on an evaluation edge keeps its value, and its next chance is the following evaluation edge. The other code is not affected.
- R8: `cal_ready` rises one edge after three conditions all hold in registered state: 2048 edges since leaving reset, at least one edge with `out_en`=1 and all-zero data, and at least one edge with `out_en`=1 and all-one data (either order). It then stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| out_en | input | 1 | 1 while the output bus is driven, 0 while it is high impedance |
| out_data | input | DATA_W (18) | Data being driven on the output bus |
| pu_cmp | input | 2 | Pull-up compare: 01 raise, 10 lower, 00/11 hold |
| pd_cmp | input | 2 | Pull-down compare: 01 raise, 10 lower, 00/11 hold |
| pu_code | output | CODE_W (6) | Pull-up drive-strength code |
| pd_code | output | CODE_W (6) | Pull-down drive-strength code |
| cal_ready | output | 1 | Calibration complete after power-up |

## Verification
Each fault in the internal state has its own sign at the ports. A slipped interval counter moves a code on the wrong edge. A wrong gate moves a code while its driver is busy. A lost saturation check shows up as a jump from 63 to 0. In each case the code differs from the cycle-by-cycle reference within one evaluation interval, at most 64 cycles. A warm-up counter or seen-read flag that is wrong shows as `cal_ready` rising too early or too late. The bench exercises this with a reset in which the warm-up ends long before both reads have occurred, so the exact edge on which the flag rises is checked.

// File: rtl/drive_cal_pkg.sv
package drive_cal_pkg;

  typedef enum logic [1:0] {
    CMP_HOLD  = 2'b00,
    CMP_RAISE = 2'b01,
    CMP_LOWER = 2'b10,
    CMP_BOTH  = 2'b11
  } cmp_e;

  localparam int unsigned DRV_PULLUP   = 0;
  localparam int unsigned DRV_PULLDOWN = 1;
  localparam int unsigned NUM_DRV      = 2;

endpackage

// File: rtl/drive_cal_rst_sync.sv
module drive_cal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/drive_cal_interval.sv
module drive_cal_interval #(
  parameter int unsigned INTERVAL = 64
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);

  localparam int unsigned CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  logic             at_last;

  always_comb begin
    at_last = (cnt_q == LAST);
    if (at_last) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = at_last;

endmodule

// File: rtl/drive_cal_stepper.sv
module drive_cal_stepper
  import drive_cal_pkg::*;
#(
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned CODE_INIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              eligible,
  input  logic [1:0]        cmp,
  output logic [CODE_W-1:0] code
);

  localparam logic [CODE_W-1:0] CODE_MAX   = '1;
  localparam logic [CODE_W-1:0] CODE_MIN   = '0;
  localparam logic [CODE_W-1:0] CODE_RESET = CODE_W'(CODE_INIT);

  logic [CODE_W-1:0] code_q;
  logic [CODE_W-1:0] code_d;
  logic              step_en;
  cmp_e              req;

  always_comb begin
    req     = cmp_e'(cmp);
    step_en = tick & eligible;
    code_d  = code_q;
    unique case (req)
      CMP_RAISE: if (code_q != CODE_MAX) code_d = code_q + 1'b1;
      CMP_LOWER: if (code_q != CODE_MIN) code_d = code_q - 1'b1;
      CMP_HOLD,
      CMP_BOTH:  code_d = code_q;
      default:   code_d = code_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= CODE_RESET;
    end else if (step_en) begin
      code_q <= code_d;
    end
  end

  assign code = code_q;

endmodule

// File: rtl/drive_cal_ready.sv
module drive_cal_ready #(
  parameter int unsigned WARMUP = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic out_en,
  input  logic all_zero,
  input  logic all_one,
  output logic ready
);

  localparam int unsigned WCNT_W = $clog2(WARMUP + 1);
  localparam logic [WCNT_W-1:0] WARM_END = WCNT_W'(WARMUP);

  logic [WCNT_W-1:0] wcnt_q;
  logic [WCNT_W-1:0] wcnt_d;
  logic              warm_done;
  logic              seen_zero_q, seen_zero_d;
  logic              seen_one_q,  seen_one_d;
  logic              ready_q,     ready_d;

  always_comb begin
    warm_done   = (wcnt_q == WARM_END);
    wcnt_d      = warm_done ? wcnt_q : wcnt_q + 1'b1;
    seen_zero_d = seen_zero_q | (out_en & all_zero);
    seen_one_d  = seen_one_q  | (out_en & all_one);
    ready_d     = ready_q | (warm_done & seen_zero_q & seen_one_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt_q      <= '0;
      seen_zero_q <= 1'b0;
      seen_one_q  <= 1'b0;
      ready_q     <= 1'b0;
    end else begin
      wcnt_q      <= wcnt_d;
      seen_zero_q <= seen_zero_d;
      seen_one_q  <= seen_one_d;
      ready_q     <= ready_d;
    end
  end

  assign ready = ready_q;

endmodule

// File: rtl/drive_cal_seq.sv
module drive_cal_seq
  import drive_cal_pkg::*;
#(
  parameter int unsigned DATA_W    = 18,
  parameter int unsigned CODE_W    = 6,
  parameter int unsigned INTERVAL  = 64,
  parameter int unsigned WARMUP    = 2048,
  parameter int unsigned CODE_INIT = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              out_en,
  input  logic [DATA_W-1:0] out_data,
  input  logic [1:0]        pu_cmp,
  input  logic [1:0]        pd_cmp,
  output logic [CODE_W-1:0] pu_code,
  output logic [CODE_W-1:0] pd_code,
  output logic              cal_ready
);

  logic              rst_int_n;
  logic              tick;
  logic              all_zero;
  logic              all_one;
  logic [NUM_DRV-1:0] elig;
  logic [1:0]         cmp_sel  [NUM_DRV];
  logic [CODE_W-1:0]  code_sel [NUM_DRV];

  drive_cal_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  drive_cal_interval #(.INTERVAL(INTERVAL)) u_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .tick  (tick)
  );

  assign all_zero = ~|out_data;
  assign all_one  = &out_data;

  assign cmp_sel[DRV_PULLUP]   = pu_cmp;
  assign cmp_sel[DRV_PULLDOWN] = pd_cmp;

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    if (d == DRV_PULLUP) begin : g_pu
      assign elig[d] = ~out_en | all_zero;
    end else begin : g_pd
      assign elig[d] = ~out_en | all_one;
    end

    drive_cal_stepper #(
      .CODE_W    (CODE_W),
      .CODE_INIT (CODE_INIT)
    ) u_step (
      .clk      (clk),
      .rst_n    (rst_int_n),
      .tick     (tick),
      .eligible (elig[d]),
      .cmp      (cmp_sel[d]),
      .code     (code_sel[d])
    );
  end

  assign pu_code = code_sel[DRV_PULLUP];
  assign pd_code = code_sel[DRV_PULLDOWN];

  drive_cal_ready #(.WARMUP(WARMUP)) u_ready (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .out_en   (out_en),
    .all_zero (all_zero),
    .all_one  (all_one),
    .ready    (cal_ready)
  );

endmodule

// File: rtl/drive_cal_seq_chk.sv
module drive_cal_seq_chk #(
  parameter int unsigned DATA_W = 18,
  parameter int unsigned CODE_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              out_en,
  input logic [DATA_W-1:0] out_data,
  input logic [1:0]        pu_cmp,
  input logic [1:0]        pd_cmp,
  input logic [CODE_W-1:0] pu_code,
  input logic [CODE_W-1:0] pd_code,
  input logic              cal_ready
);

  logic [CODE_W:0] pu_x;
  logic [CODE_W:0] pd_x;
  assign pu_x = {1'b0, pu_code};
  assign pd_x = {1'b0, pd_code};

  // R2: a code moves only on the edge where the interval ends
  assert_move_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(pu_code) || !$stable(pd_code)) |-> $past(tick));

  // R3: single step per evaluation, no wrap
  assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pu_code) |-> ((pu_x - $past(pu_x)) == 1 || ($past(pu_x) - pu_x) == 1));

  assert_single_step_pd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pd_code) |-> ((pd_x - $past(pd_x)) == 1 || ($past(pd_x) - pd_x) == 1));

  // R4: saturation at the top of the pull-up range
  assert_sat_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && pu_code == '1 && pu_cmp == 2'b01) |=> (pu_code == '1));

  // R5: pull-down code frozen while the bus drives any zero
  assert_pd_gate_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && out_en && !(&out_data)) |=> $stable(pd_code));

  // R6: pull-up code frozen while the bus drives any one
  assert_pu_gate_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && out_en && (|out_data)) |=> $stable(pu_code));

  // R8: ready is sticky until reset
  assert_ready_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cal_ready |=> cal_ready);

  // R8: ready never rises without a zero read seen earlier in some form; weak check on pd_cmp unused
  logic unused_ok;
  assign unused_ok = ^pd_cmp;

endmodule

bind drive_cal_seq drive_cal_seq_chk #(
  .DATA_W (DATA_W),
  .CODE_W (CODE_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tick      (tick),
  .out_en    (out_en),
  .out_data  (out_data),
  .pu_cmp    (pu_cmp),
  .pd_cmp    (pd_cmp),
  .pu_code   (pu_code),
  .pd_code   (pd_code),
  .cal_ready (cal_ready)
);

// File: tb/drive_cal_seq_test.sv
`timescale 1ns/1ps
module drive_cal_seq_test;

  localparam int DW = 18;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          out_en;
  logic [DW-1:0] out_data;
  logic [1:0]    pu_cmp;
  logic [1:0]    pd_cmp;
  logic [5:0]    pu_code;
  logic [5:0]    pd_code;
  logic          cal_ready;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #4 clk = ~clk;  // 125 MHz

  drive_cal_seq uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .out_en    (out_en),
    .out_data  (out_data),
    .pu_cmp    (pu_cmp),
    .pd_cmp    (pd_cmp),
    .pu_code   (pu_code),
    .pd_code   (pd_code),
    .cal_ready (cal_ready)
  );

  // ---------------- behavioural reference ----------------
  int m_wait, m_phase, m_pu, m_pd, m_warm, m_rdy;
  bit m_seen0, m_seen1;

  function automatic int step(int code, logic [1:0] c);
    if (c == 2'b01) return (code < 63) ? code + 1 : 63;
    if (c == 2'b10) return (code > 0) ? code - 1 : 0;
    return code;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_wait = 0; m_phase = 0; m_pu = 32; m_pd = 32;
      m_warm = 0; m_seen0 = 0; m_seen1 = 0; m_rdy = 0;
    end else if (m_wait < 2) begin
      m_wait++;
    end else begin
      bit ev, z, o, nr;
      m_phase++;
      ev = (m_phase % 64) == 0;
      z  = (out_data == '0);
      o  = (out_data == '1);
      nr = (m_warm >= 2048) && m_seen0 && m_seen1;
      if (ev && (!out_en || z)) m_pu = step(m_pu, pu_cmp);
      if (ev && (!out_en || o)) m_pd = step(m_pd, pd_cmp);
      if (m_warm < 2048) m_warm++;
      if (out_en && z) m_seen0 = 1;
      if (out_en && o) m_seen1 = 1;
      if (nr) m_rdy = 1;
    end
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, sampled after the edge settles
  always @(posedge clk) begin
    #2;
    if (!done) begin
      chk("R2 R3 R6 pull-up code vs model", pu_code, m_pu);
      chk("R2 R3 R5 pull-down code vs model", pd_code, m_pd);
      chk("R8 ready vs model", cal_ready, m_rdy);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic drive(logic en, logic [DW-1:0] d, logic [1:0] pu, logic [1:0] pd);
    out_en = en; out_data = d; pu_cmp = pu; pd_cmp = pd;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cyc(3);
    chk("R1 pull-up reset value", pu_code, 32);
    chk("R1 pull-down reset value", pd_code, 32);
    chk("R1 ready low in reset", cal_ready, 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int pu0, pd0;
    rst_n = 1'b0;
    drive(1'b0, '0, 2'b00, 2'b00);
    do_reset();
    cyc(2);
    chk("R1 codes still mid-scale after release", pu_code + pd_code, 64);

    // R2: first evaluation lands on edge 64 after leaving reset
    drive(1'b0, '0, 2'b01, 2'b10);
    cyc(63);
    chk("R2 no move before first evaluation", pu_code, 32);
    cyc(1);
    chk("R2 R3 first evaluation raises pull-up", pu_code, 33);
    chk("R2 R3 first evaluation lowers pull-down", pd_code, 31);
    cyc(128);
    chk("R3 high-Z both codes stepped twice more (pu)", pu_code, 35);
    chk("R3 high-Z both codes stepped twice more (pd)", pd_code, 29);

    // R5 R7: driving all ones -> only pull-down may move
    pu0 = pu_code; pd0 = pd_code;
    drive(1'b1, '1, 2'b01, 2'b10);
    cyc(128);
    chk("R7 pull-up skipped while driving ones", pu_code, pu0);
    chk("R5 pull-down stepped while driving ones", pd_code, pd0 - 2);
    chk("R8 not ready before warm-up", cal_ready, 0);

    // R6 R7: driving all zeros -> only pull-up may move
    pu0 = pu_code; pd0 = pd_code;
    drive(1'b1, '0, 2'b01, 2'b10);
    cyc(128);
    chk("R6 pull-up stepped while driving zeros", pu_code, pu0 + 2);
    chk("R7 pull-down skipped while driving zeros", pd_code, pd0);

    // mixed data: both frozen
    pu0 = pu_code; pd0 = pd_code;
    drive(1'b1, 18'h2A5C3, 2'b01, 2'b10);
    cyc(128);
    chk("R5 pull-down frozen on mixed data", pd_code, pd0);
    chk("R6 pull-up frozen on mixed data", pu_code, pu0);

    // R3 hold encodings
    pu0 = pu_code; pd0 = pd_code;
    drive(1'b0, '0, 2'b00, 2'b11);
    cyc(128);
    chk("R3 hold 00 keeps pull-up", pu_code, pu0);
    chk("R3 hold 11 keeps pull-down", pd_code, pd0);

    // R4 saturation
    drive(1'b0, '0, 2'b01, 2'b10);
    cyc(64 * 40);
    chk("R4 pull-up saturates at 63", pu_code, 63);
    chk("R4 pull-down saturates at 0", pd_code, 0);
    chk("R8 ready after warm-up and both reads", cal_ready, 1);

    // randomized compare and bus patterns, checked against the model
    for (int i = 0; i < 1500; i++) begin
      logic [DW-1:0] d;
      int sel;
      sel = $urandom_range(0, 3);
      d = (sel == 0) ? '0 : (sel == 1) ? '1 : DW'($urandom);
      drive(1'($urandom), d, 2'($urandom), 2'($urandom));
      cyc(1);
    end

    // R8: warm-up long past, reads come late, in reverse order
    drive(1'b0, '0, 2'b00, 2'b00);
    do_reset();
    cyc(2200);
    chk("R8 no ready without reads", cal_ready, 0);
    drive(1'b1, '1, 2'b00, 2'b00);
    cyc(1);
    drive(1'b0, '0, 2'b00, 2'b00);
    cyc(4);
    chk("R8 no ready with only a ones read", cal_ready, 0);
    drive(1'b1, '0, 2'b00, 2'b00);
    cyc(1);
    drive(1'b0, '0, 2'b00, 2'b00);
    cyc(1);
    chk("R8 ready one edge after flags registered", cal_ready, 1);
    cyc(100);
    chk("R8 ready stays set", cal_ready, 1);

    // R1 again: reset clears ready
    do_reset();
    cyc(1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule